// File: doc/BRIEF.md
# Programmable-Bandwidth Digital PLL Core

This block holds the datapath of a first-order phase-locked loop built entirely from logic. A reference signal and a feedback signal go to two phase detectors. One is an exclusive-OR detector, which is combinational. The other is an edge-triggered set/clear detector, which is registered. Each detector drives its own output, and the user wires whichever one suits the loop to the direction input of an up/down loop-filter counter.

The loop-filter counter runs on the K clock. Its length is selected at run time by a 4-bit modulus field, and it emits one-cycle carry and borrow pulses when it wraps. A pulse stage on the I/D clock turns those pulses into extra or missing output strobes. At rest the stage emits one strobe every second I/D clock cycle. The divide-by-N feedback counter sits outside the block and counts these strobes. The loop therefore centres at the I/D clock frequency divided by 2N.

Shortening the counter widens the bandwidth and speeds up lock. Lengthening it narrows the bandwidth. The modulus field can change while the loop runs, with no reset.

The pulse stage is a two-state machine. In `SLOT_IDLE` no strobe is due. In `SLOT_FIRE` a strobe is due. On every I/D clock edge it moves `SLOT_IDLE`→`SLOT_FIRE` or `SLOT_FIRE`→`SLOT_IDLE`; pending corrections change only the output, not the transitions.

The carry and borrow pulses are sampled by the I/D clock, so the K clock must be the same clock as the I/D clock or a synchronous submultiple of it.

Top module: `adpll_core`

## Requirements
- R1: `xor_pd` equals `ref_in` XOR `fb_in` at all times, with no clock delay.
- R2: On a K-clock edge that sees a new rise of `ref_in` and no new rise of `fb_in`, `ec_pd` becomes 1. On an edge that sees a new rise of `fb_in` and no new rise of `ref_in`, `ec_pd` becomes 0. When both or neither rise, `ec_pd` keeps its value. A rise means the input is high at this edge and was low at the previous edge.
- R3: While `mod_sel` is 0, the counter holds its value and `k_carry` and `k_borrow` stay 0.
- R4: For `mod_sel` = n (n ≥ 1), the counter is n+2 bits long. It counts up on each K-clock edge when `up_dn` is 1 and down when `up_dn` is 0. Wrapping from all-ones to zero raises `k_carry`, and wrapping from zero to all-ones raises `k_borrow`. Each pulse is high for exactly the one cycle after the wrapping edge. Starting from zero, counting up gives the first carry after 2^(n+2) edges.
- R5: `mod_sel` = 15 gives a 17-bit counter. One down step from zero raises `k_borrow`, and the following up step from 131071 raises `k_carry`.
- R6: A change of `mod_sel` takes effect at the next edge with no reset. Stored count bits above the new length are discarded.
- R7: The active-low asynchronous reset `rst_n` clears the following: the counter, both pulse outputs, `ec_pd`, the detector history, and the pending corrections. It also puts the pulse stage in `SLOT_IDLE`, so `id_out` is 0.
- R8: With no corrections pending, `id_out` is high in every second I/D clock cycle. The first high cycle is the one after the first edge following reset.
- R9: A carry pulse is latched at the next I/D clock edge. It then makes `id_out` high during the next `SLOT_IDLE` cycle, which is an extra strobe. A borrow is latched the same way and suppresses the strobe of the next `SLOT_FIRE` cycle.
- R10: If a carry and a borrow are pending together, both are cleared at the next edge and neither changes `id_out`.
- R11: A sustained `up_dn` of 1 raises the strobe count in a window above the rest rate. A sustained `up_dn` of 0 lowers it below the rest rate.
- R12: From reset with `up_dn` at 1, the first carry comes after 8 cycles for `mod_sel` = 1 and after 64 cycles for `mod_sel` = 4. The shorter counter corrects sooner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kclk | input | 1 | Clock for the detectors and the loop-filter counter |
| idclk | input | 1 | Clock for the strobe stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference signal |
| fb_in | input | 1 | Divided-down feedback signal |
| up_dn | input | 1 | Counter direction: 1 counts up, 0 counts down |
| mod_sel | input | MOD_W | Counter length select; 0 disables the counter |
| xor_pd | output | 1 | Exclusive-OR detector result |
| ec_pd | output | 1 | Edge-controlled detector result |
| k_carry | output | 1 | Counter overflow pulse, also usable for cascading |
| k_borrow | output | 1 | Counter underflow pulse, also usable for cascading |
| id_out | output | 1 | Strobe output for the external divide-by-N |

## Verification
The hardest case to reach is a carry and a borrow pending in the pulse stage at the same time, because the counter normally needs many cycles between wraps. The bench first steers a 3-bit counter until the model reports all-ones. It then flips `up_dn` on every cycle, so that a carry and a borrow arrive on consecutive edges against both slot phases. The 17-bit length is reached without waiting 131072 cycles: the bench steps down once from zero after reset and then steps up once.

// File: rtl/adpll_pkg.sv
package adpll_pkg;

    // Output slot of the strobe stage.
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_FIRE = 1'b1
    } id_slot_e;

    // Stages added to the modulus code to give the counter length.
    localparam int LEN_OFFSET = 2;

endpackage

// File: rtl/adpll_phase_det.sv
module adpll_phase_det (
    input  logic kclk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    output logic xor_pd,
    output logic ec_pd
);

    logic ref_q;
    logic fb_q;
    logic ec_q;
    logic ref_rise;
    logic fb_rise;

    always_comb begin
        ref_rise = ref_in & ~ref_q;
        fb_rise  = fb_in & ~fb_q;
    end

    always_ff @(posedge kclk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            fb_q  <= 1'b0;
            ec_q  <= 1'b0;
        end else begin
            ref_q <= ref_in;
            fb_q  <= fb_in;
            if (ref_rise && !fb_rise) begin
                ec_q <= 1'b1;
            end else if (fb_rise && !ref_rise) begin
                ec_q <= 1'b0;
            end
        end
    end

    assign xor_pd = ref_in ^ fb_in;
    assign ec_pd  = ec_q;

    // R2: a lone reference rise sets the edge detector
    p_ec_set_r2: assert property (@(posedge kclk) disable iff (!rst_n)
        (ref_in && !ref_q && !(fb_in && !fb_q)) |=> ec_pd);

    // R2: a lone feedback rise clears the edge detector
    p_ec_clr_r2: assert property (@(posedge kclk) disable iff (!rst_n)
        (fb_in && !fb_q && !(ref_in && !ref_q)) |=> !ec_pd);

    // R2: matched or absent rises leave the detector unchanged
    p_ec_hold_r2: assert property (@(posedge kclk) disable iff (!rst_n)
        ((ref_in && !ref_q) == (fb_in && !fb_q)) |=> $stable(ec_pd));

endmodule

// File: rtl/adpll_kcounter.sv
module adpll_kcounter #(
    parameter int MOD_W = 4
) (
    input  logic             kclk,
    input  logic             rst_n,
    input  logic             up_dn,
    input  logic [MOD_W-1:0] mod_sel,
    output logic             carry,
    output logic             borrow
);

    import adpll_pkg::*;

    localparam int CNT_W = (1 << MOD_W) - 1 + LEN_OFFSET;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top;
    logic [CNT_W-1:0] cur;
    logic             carry_q;
    logic             borrow_q;
    logic             at_top;
    logic             at_zero;

    always_comb begin
        top     = (CNT_W'(1) << (32'(mod_sel) + 32'(LEN_OFFSET))) - CNT_W'(1);
        cur     = cnt_q & top;
        at_top  = (cur == top);
        at_zero = (cur == '0);
    end

    always_ff @(posedge kclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            carry_q  <= 1'b0;
            borrow_q <= 1'b0;
        end else if (mod_sel == '0) begin
            carry_q  <= 1'b0;
            borrow_q <= 1'b0;
        end else if (up_dn) begin
            carry_q  <= at_top;
            borrow_q <= 1'b0;
            cnt_q    <= at_top ? '0 : cur + CNT_W'(1);
        end else begin
            carry_q  <= 1'b0;
            borrow_q <= at_zero;
            cnt_q    <= at_zero ? top : cur - CNT_W'(1);
        end
    end

    assign carry  = carry_q;
    assign borrow = borrow_q;

    // R3: a disabled counter issues no pulse
    p_no_pulse_off_r3: assert property (@(posedge kclk) disable iff (!rst_n)
        (mod_sel == '0) |=> (!carry && !borrow));

    // R4: a carry lasts one cycle
    p_carry_single_r4: assert property (@(posedge kclk) disable iff (!rst_n)
        carry |=> !carry);

    // R4: a borrow lasts one cycle
    p_borrow_single_r4: assert property (@(posedge kclk) disable iff (!rst_n)
        borrow |=> !borrow);

    // R4: carry and borrow never coincide
    p_pulse_excl_r4: assert property (@(posedge kclk) disable iff (!rst_n)
        !(carry && borrow));

endmodule

// File: rtl/adpll_idstage.sv
module adpll_idstage (
    input  logic idclk,
    input  logic rst_n,
    input  logic carry_in,
    input  logic borrow_in,
    output logic id_out
);

    import adpll_pkg::*;

    id_slot_e slot_q;
    id_slot_e slot_d;
    logic     cp_q;
    logic     bp_q;
    logic     ins;
    logic     del;
    logic     cancel;
    logic     use_c;
    logic     use_b;

    // Next-slot and pending-consumption decisions.
    always_comb begin
        cancel = cp_q & bp_q;
        ins    = cp_q & ~bp_q;
        del    = bp_q & ~cp_q;
        use_c  = cancel | (ins & (slot_q == SLOT_IDLE));
        use_b  = cancel | (del & (slot_q == SLOT_FIRE));
        unique case (slot_q)
            SLOT_IDLE: slot_d = SLOT_FIRE;
            SLOT_FIRE: slot_d = SLOT_IDLE;
        endcase
    end

    // State register with pending corrections.
    always_ff @(posedge idclk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= SLOT_IDLE;
            cp_q   <= 1'b0;
            bp_q   <= 1'b0;
        end else begin
            slot_q <= slot_d;
            cp_q   <= carry_in | (cp_q & ~use_c);
            bp_q   <= borrow_in | (bp_q & ~use_b);
        end
    end

    // Output decode.
    always_comb begin
        unique case (slot_q)
            SLOT_IDLE: id_out = ins;
            SLOT_FIRE: id_out = ~del;
        endcase
    end

    // R8: the slot alternates on every edge
    p_slot_alt_r8: assert property (@(posedge idclk) disable iff (!rst_n)
        (slot_q == SLOT_FIRE) |=> (slot_q == SLOT_IDLE));

    // R9: an incoming carry is held pending
    p_carry_latch_r9: assert property (@(posedge idclk) disable iff (!rst_n)
        carry_in |=> cp_q);

    // R9: an incoming borrow is held pending
    p_borrow_latch_r9: assert property (@(posedge idclk) disable iff (!rst_n)
        borrow_in |=> bp_q);

    // R9: a carry waits through a fire slot
    p_carry_wait_r9: assert property (@(posedge idclk) disable iff (!rst_n)
        (cp_q && !bp_q && slot_q == SLOT_FIRE) |=> cp_q);

    // R10: opposing corrections annihilate
    p_cancel_r10: assert property (@(posedge idclk) disable iff (!rst_n)
        (cp_q && bp_q && !carry_in && !borrow_in) |=> (!cp_q && !bp_q));

endmodule

// File: rtl/adpll_core.sv
module adpll_core #(
    parameter int MOD_W = 4
) (
    input  logic             kclk,
    input  logic             idclk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic             up_dn,
    input  logic [MOD_W-1:0] mod_sel,
    output logic             xor_pd,
    output logic             ec_pd,
    output logic             k_carry,
    output logic             k_borrow,
    output logic             id_out
);

    logic carry_w;
    logic borrow_w;

    adpll_phase_det u_pd (
        .kclk   (kclk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .fb_in  (fb_in),
        .xor_pd (xor_pd),
        .ec_pd  (ec_pd)
    );

    adpll_kcounter #(.MOD_W(MOD_W)) u_kc (
        .kclk    (kclk),
        .rst_n   (rst_n),
        .up_dn   (up_dn),
        .mod_sel (mod_sel),
        .carry   (carry_w),
        .borrow  (borrow_w)
    );

    adpll_idstage u_id (
        .idclk     (idclk),
        .rst_n     (rst_n),
        .carry_in  (carry_w),
        .borrow_in (borrow_w),
        .id_out    (id_out)
    );

    assign k_carry  = carry_w;
    assign k_borrow = borrow_w;

endmodule

// File: tb/test_adpll_core.sv
module test_adpll_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic       up_dn = 1'b0;
    logic [3:0] mod_sel = 4'd0;
    wire        xor_pd, ec_pd, k_carry, k_borrow, id_out;

    always #10 clk = ~clk;

    adpll_core #(.MOD_W(4)) i_adpll_core (
        .kclk(clk), .idclk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .up_dn(up_dn), .mod_sel(mod_sel), .xor_pd(xor_pd), .ec_pd(ec_pd),
        .k_carry(k_carry), .k_borrow(k_borrow), .id_out(id_out)
    );

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int n_carry = 0;
    int n_borrow = 0;

    // Behavioural reference state.
    longint m_cnt;
    bit m_carry, m_borrow, m_refq, m_fbq, m_ec, m_fire, m_cp, m_bp;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_carry = 0; m_borrow = 0; m_refq = 0; m_fbq = 0;
        m_ec = 0; m_fire = 0; m_cp = 0; m_bp = 0;
    endtask

    task automatic model_step();
        bit cancel, ins, del, use_c, use_b, n_cp, n_bp, rr, fr;
        longint top, cur;
        cancel = m_cp && m_bp;
        ins = m_cp && !m_bp;
        del = m_bp && !m_cp;
        use_c = cancel || (ins && !m_fire);
        use_b = cancel || (del && m_fire);
        n_cp = m_carry || (m_cp && !use_c);
        n_bp = m_borrow || (m_bp && !use_b);
        m_cp = n_cp; m_bp = n_bp; m_fire = !m_fire;
        rr = ref_in && !m_refq;
        fr = fb_in && !m_fbq;
        if (rr && !fr) m_ec = 1; else if (fr && !rr) m_ec = 0;
        m_refq = ref_in; m_fbq = fb_in;
        if (mod_sel == 0) begin
            m_carry = 0; m_borrow = 0;
        end else begin
            top = (64'd1 << (int'(mod_sel) + 2)) - 1;
            cur = m_cnt % (top + 1);
            if (up_dn) begin
                m_borrow = 0;
                m_carry = (cur == top);
                m_cnt = (cur == top) ? 0 : cur + 1;
            end else begin
                m_carry = 0;
                m_borrow = (cur == 0);
                m_cnt = (cur == 0) ? top : cur - 1;
            end
        end
    endtask

    function automatic bit exp_id();
        return m_fire ? !(m_bp && !m_cp) : (m_cp && !m_bp);
    endfunction

    task automatic compare_all();
        chk("R1", "xor_pd", xor_pd, ref_in ^ fb_in);
        chk("R2", "ec_pd", ec_pd, m_ec);
        chk("R4", "k_carry", k_carry, m_carry);
        chk("R4", "k_borrow", k_borrow, m_borrow);
        chk("R9", "id_out", id_out, exp_id());
        strobes += id_out;
        n_carry += k_carry;
        n_borrow += k_borrow;
    endtask

    task automatic tick(input bit r, input bit f, input bit u, input logic [3:0] m);
        ref_in = r; fb_in = f; up_dn = u; mod_sel = m;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        chk("R7", "k_carry in reset", k_carry, 0);
        chk("R7", "k_borrow in reset", k_borrow, 0);
        chk("R7", "ec_pd in reset", ec_pd, 0);
        chk("R7", "id_out in reset", id_out, 0);
        rst_n = 1'b1;
    endtask

    task automatic until_carry(input logic [3:0] m, output int cyc);
        cyc = 0;
        for (int i = 0; i < 200; i++) begin
            tick(0, 0, 1, m);
            cyc++;
            if (k_carry) break;
        end
    endtask

    bit done = 0;

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t_short, t_long;
        do_reset();

        // Rest rate with the counter disabled.
        strobes = 0; n_carry = 0; n_borrow = 0;
        for (int i = 0; i < 40; i++) tick(0, 0, 1, 4'd0);
        chk("R8", "rest strobes in 40 cycles", strobes, 20);
        chk("R3", "pulses while disabled", n_carry + n_borrow, 0);

        // Shortest length: first carry after 8 up steps.
        until_carry(4'd1, t_short);
        chk("R12", "cycles to first carry, 3 stages", t_short, 8);

        // Sustained up and down error.
        strobes = 0;
        for (int i = 0; i < 200; i++) tick(0, 0, 1, 4'd1);
        chk("R11", "strobe rate raised by up", strobes > 110, 1);
        strobes = 0;
        for (int i = 0; i < 200; i++) tick(0, 0, 0, 4'd1);
        chk("R11", "strobe rate lowered by down", strobes < 90, 1);

        // Opposing pulses on consecutive edges.
        for (int i = 0; i < 20 && m_cnt != 7; i++) tick(0, 0, 1, 4'd1);
        strobes = 0; n_carry = 0; n_borrow = 0;
        for (int i = 0; i < 60; i++) tick(0, 0, (i % 2) == 0, 4'd1);
        chk("R4", "carries equal borrows when alternating", n_carry, n_borrow);
        chk("R10", "alternating pulses leave rate near rest", (strobes >= 28 && strobes <= 32), 1);

        // Longer counter settles later.
        do_reset();
        until_carry(4'd4, t_long);
        chk("R12", "cycles to first carry, 6 stages", t_long, 64);
        chk("R12", "short counter corrects sooner", t_short < t_long, 1);

        // Full 17-stage length.
        do_reset();
        tick(0, 0, 0, 4'd15);
        chk("R5", "borrow from zero at 17 stages", k_borrow, 1);
        tick(0, 0, 1, 4'd15);
        chk("R5", "carry from 131071 at 17 stages", k_carry, 1);

        // Live length change truncates the stored count.
        do_reset();
        tick(0, 0, 0, 4'd15);
        tick(0, 0, 1, 4'd1);
        chk("R6", "carry after switch to 3 stages", k_carry, 1);
        tick(0, 0, 1, 4'd1);
        chk("R6", "no repeat carry after switch", k_carry, 0);

        // Edge-controlled detector patterns.
        do_reset();
        tick(1, 0, 0, 4'd0);
        chk("R2", "ec set by ref rise", ec_pd, 1);
        chk("R1", "xor with ref only", xor_pd, 1);
        tick(1, 0, 0, 4'd0);
        chk("R2", "ec held with ref high", ec_pd, 1);
        tick(0, 1, 0, 4'd0);
        chk("R2", "ec cleared by fb rise", ec_pd, 0);
        tick(0, 0, 0, 4'd0);
        tick(1, 1, 0, 4'd0);
        chk("R2", "ec held low on joint rise", ec_pd, 0);
        chk("R1", "xor with both high", xor_pd, 0);
        tick(0, 0, 0, 4'd0);
        tick(1, 0, 0, 4'd0);
        tick(0, 0, 0, 4'd0);
        tick(1, 1, 0, 4'd0);
        chk("R2", "ec held high on joint rise", ec_pd, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule